// File: doc/BRIEF.md
# Glitch-Free Clock Divider Bank

This block turns one fast oscillator clock into three groups of divided clocks and one feedback clock. Group A and group B each pick one of two ratios. Group C picks one of two other ratios. The feedback clock runs at a fixed ratio of eight, so a phase detector outside this block can compare it with the reference. A power-down input halves the rate of all three groups. A two-bit stop code holds chosen groups low while the others keep running. The feedback clock never stops, so the loop stays locked while groups are stopped.

All outputs come from one free-running phase counter. Its frame length is the least common multiple of every ratio the block can use, which is 24 fast cycles at the defaults. Every output rises at the start of each frame. Control inputs pass through a two-flop synchronizer. The synchronized setting is taken in only at a frame start. At that point every output has just finished a full low phase and begins a full high phase, so a change of ratio, rate or gating cannot cut a phase short.

Top module: `clkdiv_bank`

## Requirements
- R1: While rst_n is low, all four outputs are low. On the first fast-clock edge after release, all four outputs go high.
- R2: fb_out is always the fast clock divided by 8 with 4 cycles high and 4 cycles low. It is not affected by pwr_dn, the selects or shut_dn.
- R3: out_a divides by 2 when sel_a is 0 and by 4 when sel_a is 1. out_b does the same under sel_b. Each has a 50% duty cycle.
- R4: out_c divides by 4 when sel_c is 0 and by 6 when sel_c is 1, with a 50% duty cycle.
- R5: With pwr_dn at 1, the divisors of out_a, out_b and out_c are doubled (4/8 for A and B, 8/12 for C). Returning pwr_dn to 0 restores them.
- R6: Each control input is synchronized by two flops. A new setting is adopted only at a frame start, which comes once every 24 fast cycles. The setting used is the control value sampled at least two edges before that frame start. At every frame start each output that is not stopped goes high.
- R7: The shut_dn code works as follows. 00 runs all groups. 01 stops A. 10 stops A and B. 11 stops A, B and C. A stopped output is held low. Stopping and restarting happen only while that output is low.
- R8: Every high phase of every output lasts exactly half of the divisor in force for that period. No output ever shows a shortened phase.
- R9: Power-down and any stop code can be active together. The running groups then use the doubled divisors, and the stopped groups stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 1 | Group A ratio select (0: /2, 1: /4) |
| sel_b | input | 1 | Group B ratio select (0: /2, 1: /4) |
| sel_c | input | 1 | Group C ratio select (0: /4, 1: /6) |
| pwr_dn | input | 1 | Halve all group rates when 1 |
| shut_dn | input | 2 | Group stop code |
| out_a | output | 1 | Group A clock |
| out_b | output | 1 | Group B clock |
| out_c | output | 1 | Group C clock |
| fb_out | output | 1 | Divide-by-8 feedback clock |

## Verification
A fault in the frame counter or the held setting appears at the ports within one frame, at most 24 fast cycles. It shows up as an output that fails to rise at a frame start, or as a high or low phase of the wrong length. A fault in the synchronizer or in the load timing shifts the adoption of a new setting by a whole frame. The cycle-accurate reference in the bench catches this on the first fast cycle of the frame where the output and the reference differ. Gating faults show up as a stopped group that still toggles, or as a restart in the middle of a phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Synchronized control word; field order matches the synchronizer input packing
    typedef struct packed {
        logic       sel_a;
        logic       sel_b;
        logic       sel_c;
        logic       pd;
        logic [1:0] shut;
    } ctl_t;

    function automatic int gcd_f(input int a_in, input int b_in);
        int a;
        int b;
        int t;
        a = a_in;
        b = b_in;
        while (b != 0) begin
            t = b;
            b = a % b;
            a = t;
        end
        return a;
    endfunction

    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    function automatic int max_f(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkdiv_sync2.sv
module clkdiv_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

    // Checker: edges seen since reset, saturating
    logic [1:0] vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              vld_q <= '0;
        else if (vld_q != 2'd3)  vld_q <= vld_q + 2'd1;
    end

    // R6: synchronized value is exactly two edges old
    assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int CW = 5,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nx,
    input  logic [DW-1:0] div_nx,
    input  logic          gate_nx,
    output logic          clk_out
);

    localparam int WW = (CW > DW) ? CW : DW;

    typedef struct packed {
        logic          q;
        logic [DW-1:0] div;
    } st_t;

    st_t           st_d, st_q;
    logic [WW-1:0] phase;
    logic          high_half;

    always_comb begin
        phase     = WW'(cnt_nx) % WW'(div_nx);
        high_half = phase < (WW'(div_nx) >> 1);
        st_d.q    = !gate_nx && high_half;
        st_d.div  = div_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out = st_q.q;

    // Checker: length of the current high phase and the divisor it started with
    logic [DW:0]   hi_len_q;
    logic [DW-1:0] div_rise_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q   <= '0;
            div_rise_q <= '0;
        end else begin
            hi_len_q <= clk_out ? hi_len_q + 1'b1 : '0;
            if (clk_out && hi_len_q == '0) div_rise_q <= st_q.div;
        end
    end

    // R8: a finished high phase lasts exactly half the divisor of its period
    assert_high_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> (hi_len_q == (DW+1)'(div_rise_q >> 1)));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int DIV_AB0 = 2,
    parameter int DIV_AB1 = 4,
    parameter int DIV_C0  = 4,
    parameter int DIV_C1  = 6,
    parameter int DIV_FB  = 8,
    parameter int PD_MULT = 2
) (
    input  logic       clk_fast,
    input  logic       rst_n,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       sel_c,
    input  logic       pwr_dn,
    input  logic [1:0] shut_dn,
    output logic       out_a,
    output logic       out_b,
    output logic       out_c,
    output logic       fb_out
);

    localparam int DIV_MAX = max_f(PD_MULT * max_f(max_f(DIV_AB0, DIV_AB1), max_f(DIV_C0, DIV_C1)), DIV_FB);
    localparam int DW      = $clog2(DIV_MAX + 1);
    localparam int FR_PD   = lcm_f(lcm_f(DIV_AB0 * PD_MULT, DIV_AB1 * PD_MULT),
                                   lcm_f(DIV_C0 * PD_MULT, DIV_C1 * PD_MULT));
    localparam int FR_NRM  = lcm_f(lcm_f(DIV_AB0, DIV_AB1), lcm_f(lcm_f(DIV_C0, DIV_C1), DIV_FB));
    localparam int FRAME   = lcm_f(FR_PD, FR_NRM);
    localparam int CW      = $clog2(FRAME);
    localparam int NCH     = 4;
    localparam int FBW     = $clog2(DIV_FB + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        ctl_t          ctl;
    } st_t;

    function automatic logic [DW-1:0] div_of(input int ch, input ctl_t c);
        int base;
        case (ch)
            0:       base = c.sel_a ? DIV_AB1 : DIV_AB0;
            1:       base = c.sel_b ? DIV_AB1 : DIV_AB0;
            2:       base = c.sel_c ? DIV_C1 : DIV_C0;
            default: base = DIV_FB;
        endcase
        if (ch < 3 && c.pd) base = base * PD_MULT;
        return DW'(base);
    endfunction

    function automatic logic gate_of(input int ch, input ctl_t c);
        case (ch)
            0:       return c.shut != 2'b00;
            1:       return c.shut[1];
            2:       return c.shut == 2'b11;
            default: return 1'b0;
        endcase
    endfunction

    ctl_t                  ctl_sync;
    logic [$bits(ctl_t)-1:0] sync_raw;
    st_t                   st_d, st_q;
    logic [NCH-1:0][DW-1:0] div_nx;
    logic [NCH-1:0]        gate_nx;
    logic [NCH-1:0]        gate_now;
    logic [NCH-1:0]        clk_vec;

    clkdiv_sync2 #(.W($bits(ctl_t))) u_sync (
        .clk  (clk_fast),
        .rst_n(rst_n),
        .din  ({sel_a, sel_b, sel_c, pwr_dn, shut_dn}),
        .dout (sync_raw)
    );

    assign ctl_sync = ctl_t'(sync_raw);

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == CW'(FRAME - 1)) ? '0 : st_q.cnt + 1'b1;
        if (st_d.cnt == '0) st_d.ctl = ctl_sync;
        for (int ch = 0; ch < NCH; ch++) begin
            div_nx[ch]   = div_of(ch, st_d.ctl);
            gate_nx[ch]  = gate_of(ch, st_d.ctl);
            gate_now[ch] = gate_of(ch, st_q.ctl);
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(FRAME - 1);
            st_q.ctl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        clkdiv_phase #(.CW(CW), .DW(DW)) u_phase (
            .clk    (clk_fast),
            .rst_n  (rst_n),
            .cnt_nx (st_d.cnt),
            .div_nx (div_nx[g]),
            .gate_nx(gate_nx[g]),
            .clk_out(clk_vec[g])
        );
    end

    assign out_a  = clk_vec[0];
    assign out_b  = clk_vec[1];
    assign out_c  = clk_vec[2];
    assign fb_out = clk_vec[3];

    // Checker: feedback period measured between rising edges
    logic           fb_prev_q;
    logic           fb_seen_q;
    logic [FBW-1:0] fb_per_q;
    logic           fb_rise;
    assign fb_rise = fb_out && !fb_prev_q;
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            fb_prev_q <= 1'b0;
            fb_seen_q <= 1'b0;
            fb_per_q  <= '0;
        end else begin
            fb_prev_q <= fb_out;
            if (fb_rise) begin
                fb_seen_q <= 1'b1;
                fb_per_q  <= FBW'(1);
            end else if (fb_per_q != '1) begin
                fb_per_q  <= fb_per_q + 1'b1;
            end
        end
    end

    // R2: feedback period never changes, whatever the controls do
    assert_fb_period_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fb_rise && fb_seen_q) |-> (fb_per_q == FBW'(DIV_FB)));

    // R6: the held setting moves only at a frame start
    assert_ctl_frame_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q.ctl != $past(st_q.ctl)) |-> (st_q.cnt == '0));

    // R7 and R9: gating of each group changes only after that output was low
    assert_gate_low_a_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (gate_now[0] != $past(gate_now[0])) |-> ($past(out_a) == 1'b0));
    assert_gate_low_b_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (gate_now[1] != $past(gate_now[1])) |-> ($past(out_b) == 1'b0));
    assert_gate_low_c_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (gate_now[2] != $past(gate_now[2])) |-> ($past(out_c) == 1'b0));

    // R7: a stopped group stays low
    assert_stopped_low_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (gate_now[0] && $past(gate_now[0])) |-> !out_a);

endmodule

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, pwr_dn = 1'b0;
    logic [1:0] shut_dn = 2'b00;
    logic       out_a, out_b, out_c, fb_out;

    always #10 clk = ~clk;

    clkdiv_bank u_dut (
        .clk_fast(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .pwr_dn(pwr_dn), .shut_dn(shut_dn),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .fb_out(fb_out)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Behavioural reference: frame count, two-stage input history, held setting
    int         m_cnt = 23;
    logic [5:0] h1 = '0, h2 = '0;
    logic       m_sa = 0, m_sb = 0, m_sc = 0, m_pd = 0;
    logic [1:0] m_sh = 0;
    int         hi_run [4] = '{0, 0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 23;
            {m_sa, m_sb, m_sc, m_pd, m_sh} = 6'b0;
            h1 = '0;
            h2 = '0;
        end else begin
            m_cnt = (m_cnt + 1) % 24;
            if (m_cnt == 0) {m_sa, m_sb, m_sc, m_pd, m_sh} = h2;
            h2 = h1;
            h1 = {sel_a, sel_b, sel_c, pwr_dn, shut_dn};
        end
    end

    function automatic int m_div(input int ch);
        int d;
        case (ch)
            0:       d = m_sa ? 4 : 2;
            1:       d = m_sb ? 4 : 2;
            2:       d = m_sc ? 6 : 4;
            default: d = 8;
        endcase
        if (ch < 3 && m_pd) d = d * 2;
        return d;
    endfunction

    function automatic bit m_gate(input int ch);
        case (ch)
            0:       return m_sh != 2'b00;
            1:       return m_sh[1];
            2:       return m_sh == 2'b11;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input int ch);
        if (ch == 3)    return "R2";
        if (m_gate(ch)) return m_pd ? "R9" : "R7";
        if (m_pd)       return "R5";
        if (ch == 2)    return "R4";
        return "R3";
    endfunction

    function automatic bit legal_half(input int ch, input int len);
        if (ch == 3) return len == 4;
        if (ch == 2) return len == 2 || len == 3 || len == 4 || len == 6;
        return len == 1 || len == 2 || len == 4;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic outv(input int ch);
        case (ch)
            0:       return out_a;
            1:       return out_b;
            2:       return out_c;
            default: return fb_out;
        endcase
    endfunction

    // Compare against the reference away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < 4; ch++) begin
                int  d;
                bit  expv;
                logic act;
                d    = m_div(ch);
                expv = !m_gate(ch) && ((m_cnt % d) < d / 2);
                act  = outv(ch);
                check(act === expv, tag_of(ch), $sformatf("output %0d level", ch), int'(act), int'(expv));
                if (m_cnt == 0 && !m_gate(ch))
                    check(act === 1'b1, "R6", $sformatf("output %0d rise at frame start", ch), int'(act), 1);
                if (act === 1'b1) begin
                    hi_run[ch]++;
                end else begin
                    if (hi_run[ch] > 0)
                        check(legal_half(ch, hi_run[ch]), "R8", $sformatf("output %0d high length", ch), hi_run[ch], m_div(ch) / 2);
                    hi_run[ch] = 0;
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check({out_a, out_b, out_c, fb_out} === 4'b0000, "R1", "outputs in reset",
                  int'({out_a, out_b, out_c, fb_out}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check({out_a, out_b, out_c, fb_out} === 4'b1111, "R1", "outputs after release",
              int'({out_a, out_b, out_c, fb_out}), 15);
        run(60);
        sel_a = 1'b1;                       // R3
        run(60);
        sel_b = 1'b1; sel_c = 1'b1;         // R3, R4
        run(60);
        pwr_dn = 1'b1;                      // R5
        run(80);
        sel_a = 1'b0;
        run(60);
        pwr_dn = 1'b0;
        run(50);
        shut_dn = 2'b01;                    // R7
        run(60);
        shut_dn = 2'b10;
        run(60);
        shut_dn = 2'b11;
        run(60);
        pwr_dn = 1'b1;                      // R9
        run(80);
        shut_dn = 2'b01;
        run(60);
        shut_dn = 2'b00;
        run(60);
        pwr_dn = 1'b0; sel_c = 1'b0;
        run(60);
        pwr_dn = 1'b1;                      // R6: short pulse between frame starts
        run(1);
        pwr_dn = 1'b0;
        run(50);
        for (int i = 0; i < 60; i++) begin
            {sel_a, sel_b, sel_c, pwr_dn, shut_dn} = 6'((i * 37 + 11) % 64);
            run(3 + (i * 5) % 29);
        end
        run(50);
        finish_test();
    end

endmodule